// File: doc/BRIEF.md
# Window Watchdog with Timed Reset Output

This block supervises a host processor with a watchdog that has both a lower and an upper limit on the acknowledgement interval. After power-on it is idle. The host arms it by writing 1 to the enable bit. The host must then write 1 to that bit again at intervals that are neither too short nor too long. An acknowledgement that arrives while the prohibited window is still open counts as a fault. So does letting the programmable timeout run out. Either fault drives the active-low reset output low after a short settling delay and holds it low for a fixed duration.

Time is counted in a millisecond tick that a prescaler derives from the clock. The timeout is a multiple of a tick step, set by a small field. Once a watchdog reset completes, the block goes back to idle, and the host must arm it again. The prohibited window and the settling delay are counted in clock cycles. The timeout and the reset hold time are counted in ticks. Every one of these durations is a parameter.

Top module: `win_watchdog`

## Requirements
- R1: After power-on reset the output is high and the watchdog is idle; without a write of 1 to the enable bit it never asserts the output, however long it runs.
- R2: A write of 1 to the enable bit while idle arms the watchdog at that clock edge E. With no further write, the output goes low exactly (field+1)·STEP_TICKS·TICK_CYCLES + DELAY_CYCLES clock edges after E, where field is the value of the timeout field.
- R3: Once low, the output stays low for exactly HOLD_TICKS·TICK_CYCLES clock edges and then returns high.
- R4: When a watchdog reset ends, the watchdog is idle again, so the output stays high until the watchdog is armed anew.
- R5: A write of 1 to the enable bit at clock edge k after the arming or the last valid acknowledgement, with 1 ≤ k ≤ PROHIB_CYCLES, is an early acknowledgement. The output goes low exactly DELAY_CYCLES edges after edge k.
- R6: A write of 1 at edge k with k > PROHIB_CYCLES that comes before the timeout is a valid acknowledgement. It restarts the prohibited window and the timeout, which are then measured from edge k exactly as in R2 and R5.
- R7: A write of 0 to the enable bit while armed returns the watchdog to idle, and no reset follows.
- R8: Writes to the enable bit during the settling delay or while the output is low are ignored. They change neither when the reset falls or rises, nor the idle state that follows it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset, asynchronous |
| en_wr | input | 1 | Write strobe for the enable bit |
| en_wdata | input | 1 | Value written to the enable bit |
| tmo_wr | input | 1 | Write strobe for the timeout field |
| tmo_wdata | input | TMO_W | Value written to the timeout field |
| wd_rst_n | output | 1 | Active-low watchdog reset output |

## Verification
The bench builds the block with a 10-cycle tick, a timeout step of 2 ticks, a prohibited window of 25 cycles, a 4-cycle settling delay and a hold of 6 ticks. Every timeout from 40 to 320 cycles, and both edges of the prohibited window, then fall within a few hundred cycles each. With these values the bench can test early and valid acknowledgements one cycle either side of the window boundary. It can also check every falling and rising edge of the reset output to the exact cycle, across randomly chosen timeout fields and acknowledgement times.

// File: rtl/wwd_pkg.sv
package wwd_pkg;

    // Supervisor states
    typedef enum logic [1:0] {
        WD_OFF  = 2'd0,   // idle, not supervising
        WD_RUN  = 2'd1,   // armed, counting window and timeout
        WD_WAIT = 2'd2,   // fault seen, settling delay before reset
        WD_HOLD = 2'd3    // reset output driven low
    } wd_state_e;

endpackage

// File: rtl/wwd_tick.sv
module wwd_tick #(
    parameter int TICK_CYCLES = 8000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic tick
);
    localparam int PRE_W = $clog2(TICK_CYCLES + 1);

    logic [PRE_W-1:0] pre_d, pre_q;

    assign tick = (pre_q == PRE_W'(TICK_CYCLES - 1));

    always_comb begin
        if (clr || tick) pre_d = '0;
        else             pre_d = pre_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
    end
endmodule

// File: rtl/wwd_core.sv
module wwd_core
    import wwd_pkg::*;
#(
    parameter int TMO_W         = 4,
    parameter int STEP_TICKS    = 32,
    parameter int PROHIB_CYCLES = 20000,
    parameter int DELAY_CYCLES  = 4,
    parameter int HOLD_TICKS    = 100
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             en_wr,
    input  logic             en_wdata,
    input  logic             tmo_wr,
    input  logic [TMO_W-1:0] tmo_wdata,
    output logic             tick_clr,
    output logic             rst_out_n,
    output wd_state_e        state,
    output logic             early
);
    localparam int MAX_TICKS = (2 ** TMO_W) * STEP_TICKS;
    localparam int MAXT      = (MAX_TICKS > HOLD_TICKS) ? MAX_TICKS : HOLD_TICKS;
    localparam int TCK_W     = $clog2(MAXT + 1);
    localparam int WIN_W     = $clog2(PROHIB_CYCLES + 1);
    localparam int DLY_W     = $clog2(DELAY_CYCLES + 1);

    typedef struct packed {
        wd_state_e        st;
        logic [TMO_W-1:0] fld;
        logic [TCK_W-1:0] tcnt;
        logic [WIN_W-1:0] wcnt;
        logic [DLY_W-1:0] dcnt;
    } core_t;

    core_t            r_d, r_q;
    logic [TCK_W-1:0] limit;
    logic [TCK_W-1:0] tnext;
    logic             ack;

    assign early     = (r_q.wcnt < WIN_W'(PROHIB_CYCLES));
    assign state     = r_q.st;
    assign rst_out_n = (r_q.st != WD_HOLD);

    always_comb begin
        r_d      = r_q;
        tick_clr = 1'b0;
        limit    = TCK_W'((32'(r_q.fld) + 32'd1) * 32'(STEP_TICKS));
        tnext    = r_q.tcnt + 1'b1;
        ack      = en_wr && en_wdata;

        if (tmo_wr) r_d.fld = tmo_wdata;

        case (r_q.st)
            WD_OFF: begin
                if (ack) begin
                    r_d.st   = WD_RUN;
                    r_d.tcnt = '0;
                    r_d.wcnt = '0;
                    tick_clr = 1'b1;
                end
            end
            WD_RUN: begin
                if (early) r_d.wcnt = r_q.wcnt + 1'b1;
                if (tick)  r_d.tcnt = tnext;
                if (tick && (tnext >= limit)) begin
                    // timeout has priority over a simultaneous write
                    r_d.st   = WD_WAIT;
                    r_d.dcnt = '0;
                end else if (en_wr) begin
                    if (!en_wdata) begin
                        r_d.st = WD_OFF;
                    end else if (early) begin
                        r_d.st   = WD_WAIT;
                        r_d.dcnt = '0;
                    end else begin
                        r_d.tcnt = '0;
                        r_d.wcnt = '0;
                        tick_clr = 1'b1;
                    end
                end
            end
            WD_WAIT: begin
                if (r_q.dcnt == DLY_W'(DELAY_CYCLES - 1)) begin
                    r_d.st   = WD_HOLD;
                    r_d.tcnt = '0;
                    tick_clr = 1'b1;
                end else begin
                    r_d.dcnt = r_q.dcnt + 1'b1;
                end
            end
            WD_HOLD: begin
                if (tick) begin
                    if (tnext == TCK_W'(HOLD_TICKS)) r_d.st = WD_OFF;
                    else                              r_d.tcnt = tnext;
                end
            end
            default: r_d.st = WD_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st   <= WD_OFF;
            r_q.fld  <= '0;
            r_q.tcnt <= '0;
            r_q.wcnt <= '0;
            r_q.dcnt <= '0;
        end else begin
            r_q <= r_d;
        end
    end
endmodule

// File: rtl/win_watchdog.sv
module win_watchdog
    import wwd_pkg::*;
#(
    parameter int TICK_CYCLES   = 8000,
    parameter int TMO_W         = 4,
    parameter int STEP_TICKS    = 32,
    parameter int PROHIB_CYCLES = 20000,
    parameter int DELAY_CYCLES  = 4,
    parameter int HOLD_TICKS    = 100
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_wr,
    input  logic             en_wdata,
    input  logic             tmo_wr,
    input  logic [TMO_W-1:0] tmo_wdata,
    output logic             wd_rst_n
);
    logic      tick;
    logic      tick_clr;
    wd_state_e core_state;
    logic      core_early;

    wwd_tick #(
        .TICK_CYCLES(TICK_CYCLES)
    ) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (tick_clr),
        .tick (tick)
    );

    wwd_core #(
        .TMO_W        (TMO_W),
        .STEP_TICKS   (STEP_TICKS),
        .PROHIB_CYCLES(PROHIB_CYCLES),
        .DELAY_CYCLES (DELAY_CYCLES),
        .HOLD_TICKS   (HOLD_TICKS)
    ) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .en_wr    (en_wr),
        .en_wdata (en_wdata),
        .tmo_wr   (tmo_wr),
        .tmo_wdata(tmo_wdata),
        .tick_clr (tick_clr),
        .rst_out_n(wd_rst_n),
        .state    (core_state),
        .early    (core_early)
    );
endmodule

// File: rtl/wwd_chk.sv
module wwd_chk
    import wwd_pkg::*;
(
    input logic      clk,
    input logic      rst_n,
    input logic      en_wr,
    input logic      en_wdata,
    input logic      wd_rst_n,
    input wd_state_e state,
    input logic      early
);
    assert_stay_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == WD_OFF && !(en_wr && en_wdata)) |=> (state == WD_OFF));

    assert_arm_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == WD_OFF && en_wr && en_wdata) |=> (state == WD_RUN));

    assert_fall_after_delay_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wd_rst_n) |-> ($past(state) == WD_WAIT));

    assert_hold_min_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wd_rst_n) |=> !wd_rst_n);

    assert_back_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wd_rst_n) |-> (state == WD_OFF));

    assert_early_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == WD_RUN && en_wr && en_wdata && early) |=> (state == WD_WAIT));

    assert_valid_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == WD_RUN && en_wr && en_wdata && !early)
        |=> ((state == WD_RUN && early) || state == WD_WAIT));

    assert_disable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == WD_RUN && en_wr && !en_wdata) |=> (state == WD_OFF || state == WD_WAIT));

    assert_ignore_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == WD_WAIT || state == WD_HOLD) |=> (state != WD_RUN));
endmodule

bind win_watchdog wwd_chk u_wwd_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .en_wr   (en_wr),
    .en_wdata(en_wdata),
    .wd_rst_n(wd_rst_n),
    .state   (core_state),
    .early   (core_early)
);

// File: tb/win_watchdog_tb.sv
module win_watchdog_tb;
    localparam int CLK_PERIOD = 10;
    localparam int TICK   = 10;
    localparam int TMO_W  = 4;
    localparam int STEP   = 2;
    localparam int PROHIB = 25;
    localparam int DLY    = 4;
    localparam int HOLD   = 6;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             en_wr = 1'b0;
    logic             en_wdata = 1'b0;
    logic             tmo_wr = 1'b0;
    logic [TMO_W-1:0] tmo_wdata = '0;
    logic             wd_rst_n;

    int checks = 0;
    int errors = 0;
    int now_e  = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    win_watchdog #(
        .TICK_CYCLES  (TICK),
        .TMO_W        (TMO_W),
        .STEP_TICKS   (STEP),
        .PROHIB_CYCLES(PROHIB),
        .DELAY_CYCLES (DLY),
        .HOLD_TICKS   (HOLD)
    ) u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_wr    (en_wr),
        .en_wdata (en_wdata),
        .tmo_wr   (tmo_wr),
        .tmo_wdata(tmo_wdata),
        .wd_rst_n (wd_rst_n)
    );

    // expected-value functions from the requirements
    function automatic int fall_after_timeout(int f);
        return (f + 1) * STEP * TICK + DLY;
    endfunction

    function automatic int hold_len();
        return HOLD * TICK;
    endfunction

    function automatic bit is_early(int k);
        return (k >= 1) && (k <= PROHIB);
    endfunction

    task automatic chk(string tag, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: wd_rst_n=%0b expected %0b (edge %0d)", tag, act, exp, now_e);
        end
    endtask

    task automatic wait_to(int target);
        while (now_e < target) begin
            @(negedge clk);
            now_e++;
        end
    endtask

    // called at a negedge; the write hits the next rising edge
    task automatic pulse_en(logic v);
        en_wr = 1'b1;
        en_wdata = v;
        @(posedge clk);
        @(negedge clk);
        en_wr = 1'b0;
        en_wdata = 1'b0;
        now_e++;
    endtask

    task automatic write_field(int f);
        tmo_wr = 1'b1;
        tmo_wdata = TMO_W'(f);
        @(negedge clk);
        tmo_wr = 1'b0;
        now_e++;
    endtask

    task automatic arm();
        pulse_en(1'b1);
        now_e = 0;
    endtask

    // reset falls at edge tf, then is held and released
    task automatic expect_fall(int tf, string tag);
        wait_to(tf - 1);
        chk({tag, " high before fall"}, wd_rst_n, 1'b1);
        wait_to(tf);
        chk({tag, " low at fall"}, wd_rst_n, 1'b0);
        wait_to(tf + hold_len() - 1);
        chk("R3 still low at end of hold", wd_rst_n, 1'b0);
        wait_to(tf + hold_len());
        chk("R3 high after hold", wd_rst_n, 1'b1);
    endtask

    task automatic expect_idle(int f, string tag);
        int base;
        base = now_e;
        wait_to(base + fall_after_timeout(f) + 20);
        chk(tag, wd_rst_n, 1'b1);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog: run did not complete");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int seed;
        int f;
        int k;
        int mode;
        seed = $urandom(32'd20240611);

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        now_e = 0;
        chk("R1 high after power-on", wd_rst_n, 1'b1);
        write_field(15);
        expect_idle(15, "R1 idle without arming");

        // R2 directed timeout with field 1, R3 hold, R4 idle afterwards
        write_field(1);
        @(negedge clk);
        arm();
        expect_fall(fall_after_timeout(1), "R2 timeout f=1");
        expect_idle(1, "R4 idle after watchdog reset");

        // R5 boundary: acknowledgement at the last prohibited edge
        write_field(3);
        arm();
        wait_to(PROHIB - 1);
        pulse_en(1'b1);
        expect_fall(PROHIB + DLY, "R5 early ack at window edge");
        expect_idle(3, "R4 idle after early-ack reset");

        // R6 boundary: first allowed edge restarts the timeout
        arm();
        wait_to(PROHIB);
        pulse_en(1'b1);
        now_e = 0;
        wait_to(DLY);
        chk("R6 no reset after valid ack", wd_rst_n, 1'b1);
        expect_fall(fall_after_timeout(3), "R6 timeout from valid ack");

        // R7 disable while armed, then re-arm works
        write_field(2);
        arm();
        wait_to(9);
        pulse_en(1'b0);
        expect_idle(2, "R7 disabled, no reset");
        arm();
        expect_fall(fall_after_timeout(2), "R2 timeout after re-arm");

        // R8 write during settling delay
        arm();
        pulse_en(1'b1);              // early ack at edge 1
        pulse_en(1'b1);              // edge 2, during delay
        expect_fall(1 + DLY, "R8 write in delay ignored");
        expect_idle(2, "R8 idle after delay write");

        // R8 write during hold
        arm();
        wait_to(fall_after_timeout(2) + 3);
        chk("R8 low before hold write", wd_rst_n, 1'b0);
        pulse_en(1'b1);
        wait_to(fall_after_timeout(2) + hold_len() - 1);
        chk("R8 hold unchanged by write", wd_rst_n, 1'b0);
        wait_to(fall_after_timeout(2) + hold_len());
        chk("R8 release time unchanged", wd_rst_n, 1'b1);
        expect_idle(2, "R8 idle after hold write");

        // constrained random scenarios
        for (int it = 0; it < 12; it++) begin
            f = 1 + int'($urandom % 15);
            mode = int'($urandom % 3);
            write_field(f);
            @(negedge clk);
            arm();
            if (mode == 0) begin
                expect_fall(fall_after_timeout(f), "R2 random timeout");
            end else if (mode == 1) begin
                k = PROHIB + 1 + int'($urandom % ((f + 1) * STEP * TICK - PROHIB - 1));
                wait_to(k - 1);
                pulse_en(1'b1);
                now_e = 0;
                expect_fall(fall_after_timeout(f), "R6 random valid ack");
            end else begin
                k = 1 + int'($urandom % PROHIB);
                if (!is_early(k)) k = PROHIB;
                wait_to(k - 1);
                pulse_en(1'b1);
                expect_fall(k + DLY, "R5 random early ack");
            end
            wait_to(now_e + 3);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule